// File: doc/BRIEF.md
# Hart base counter CSR unit

This unit keeps the user-visible event counters of one processor hart and answers counter reads that the decode stage issues by CSR number. Storage has room for 32 counters of 64 bits each. Three of them are live: a cycle count, a time count that advances once per clock, and a count of retired instructions. The other 29 entries are tied to zero and have no write path. All counters wrap modulo 2^64.

The commit stage presents a retire count of 0 to 4 each cycle, and that count is added to the retired-instruction counter in a single step. A read names a 12-bit CSR number and carries the source-register field of the instruction and a mode bit that selects 32-bit or 64-bit operation. The unit decides what kind of read it is and returns the registered result one cycle later, along with a decode-fault flag. A read of the retired-instruction counter that coincides with retirements already includes them.

The read path is a small state machine. Its state register holds the read kind for the cycle after a request: `RD_IDLE` (no request), `RD_NONE` (a CSR number this unit does not own), `RD_FULL` (whole 64-bit value), `RD_LOW` (bits 31:0), `RD_HIGH` (bits 63:32) and `RD_FAULT` (illegal access). Each cycle the state is reloaded from the decode of the current request. There are no other transitions: any state can follow any state, and `RD_IDLE` is entered whenever no request is present.

Top module: `hart_counter_unit`

## Requirements
- R1: While reset is asserted, rd_valid, rd_fault and rd_data are all zero. All counters restart from zero, so a cycle read issued in the first cycle after reset is released returns 0.
- R2: The cycle counter (CSR 0xC00, high half 0xC80) and the time counter (CSR 0xC01, high half 0xC81) each advance by one on every clock edge outside reset, and they always hold equal values.
- R3: The retired-instruction counter (CSR 0xC02, high half 0xC82) advances by retire_cnt on every clock edge outside reset. retire_cnt is never larger than 4.
- R4: A read of the retired-instruction counter returns the counter value plus the retire_cnt presented in the same cycle as the read.
- R5: In 64-bit mode (rd_xlen32 = 0), a read of 0xC00, 0xC01 or 0xC02 with rd_rs1 = 0 returns the full 64-bit counter value with rd_fault = 0.
- R6: In 32-bit mode (rd_xlen32 = 1), a read of 0xC00, 0xC01 or 0xC02 with rd_rs1 = 0 returns counter bits 31:0 in rd_data[31:0], with rd_data[63:32] = 0 and no fault.
- R7: In 32-bit mode, a read of 0xC80, 0xC81 or 0xC82 with rd_rs1 = 0 returns counter bits 63:32 in rd_data[31:0], with rd_data[63:32] = 0 and no fault.
- R8: In 64-bit mode, a read of 0xC80, 0xC81 or 0xC82 sets rd_fault and returns rd_data = 0.
- R9: A read of any of the six counter CSRs with a nonzero rd_rs1 sets rd_fault and returns rd_data = 0, in either mode.
- R10: A read of any other CSR number returns rd_data = 0 with rd_fault = 0.
- R11: rd_valid is high exactly one cycle after a cycle in which rd_req is high. When rd_valid is low, rd_data and rd_fault are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; counters advance on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| retire_cnt | input | 3 | Instructions retired this cycle, 0 to 4 |
| rd_req | input | 1 | Counter read request |
| rd_csr | input | 12 | CSR number of the read |
| rd_rs1 | input | 5 | Source-register field of the reading instruction |
| rd_xlen32 | input | 1 | 1 selects 32-bit mode, 0 selects 64-bit mode |
| rd_data | output | 64 | Registered read result |
| rd_valid | output | 1 | Result valid, one cycle after rd_req |
| rd_fault | output | 1 | Decode fault for the read answered this cycle |

## Verification
The bench goes after same-cycle retirement: instret reads under retire counts from 0 to 4, including back-to-back reads during bursts of 4. A design that samples the counter before adding retirements returns a value that lags by exactly the same-cycle count. It also crosses both modes with all six counter CSRs and with neighbours just outside them (0xC03, 0xC1F, 0xC83 and unrelated numbers). A wrong decode shows up there as a fault on a legal high-half read, a missing fault in 64-bit mode, the low word returned in place of the high word, or nonzero data for a CSR the unit does not own. Reads with a nonzero rs1 target the fault path: a design that checks rs1 only in one mode, or leaves data on the bus alongside the fault, is caught.

// File: rtl/cntr_pkg.sv
package cntr_pkg;

    localparam int CNT_W      = 64;
    localparam int NUM_CNT    = 32;
    localparam int CSR_W      = 12;
    localparam int RS_W       = 5;
    localparam int RET_W      = 3;
    localparam int MAX_RETIRE = 4;

    localparam int IDX_CYCLE   = 0;
    localparam int IDX_TIME    = 1;
    localparam int IDX_INSTRET = 2;
    localparam int NUM_LIVE    = 3;

    localparam logic [11:0] CSR_LO_BASE = 12'hC00;
    localparam logic [11:0] CSR_HI_BASE = 12'hC80;

    typedef enum logic [2:0] {
        RD_IDLE,
        RD_NONE,
        RD_FULL,
        RD_LOW,
        RD_HIGH,
        RD_FAULT
    } rd_kind_e;

endpackage

// File: rtl/cntr_bank.sv
module cntr_bank
    import cntr_pkg::*;
#(
    parameter int CW  = CNT_W,
    parameter int NC  = NUM_CNT,
    parameter int RW  = RET_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [RW-1:0]              retire_cnt,
    output logic [NC-1:0][CW-1:0]      vis_cnt,
    output logic [NUM_LIVE-1:0][CW-1:0] live_q
);

    logic [CW-1:0] retire_ext;
    assign retire_ext = {{(CW-RW){1'b0}}, retire_cnt};

    for (genvar g = 0; g < NC; g++) begin : g_cnt
        if (g == IDX_CYCLE || g == IDX_TIME) begin : g_tick
            logic [CW-1:0] cnt_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_q + CW'(1);
            end
            assign vis_cnt[g] = cnt_q;
            assign live_q[g]  = cnt_q;
        end else if (g == IDX_INSTRET) begin : g_ret
            logic [CW-1:0] cnt_q;
            logic [CW-1:0] cnt_d;
            assign cnt_d = cnt_q + retire_ext;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end
            assign vis_cnt[g] = cnt_d;
            assign live_q[g]  = cnt_q;
        end else begin : g_idle
            assign vis_cnt[g] = '0;
        end
    end

endmodule

// File: rtl/cntr_csr_decode.sv
module cntr_csr_decode
    import cntr_pkg::*;
#(
    parameter int CSW = CSR_W,
    parameter int RSW = RS_W,
    parameter int NC  = NUM_CNT
) (
    input  logic                   rd_req,
    input  logic [CSW-1:0]         rd_csr,
    input  logic [RSW-1:0]         rd_rs1,
    input  logic                   rd_xlen32,
    output rd_kind_e               kind_d,
    output logic [$clog2(NC)-1:0]  idx_d
);

    localparam int IW = $clog2(NC);
    localparam logic [CSW-1:0] LO_FIRST = CSW'(CSR_LO_BASE);
    localparam logic [CSW-1:0] LO_LAST  = CSW'(CSR_LO_BASE + NUM_LIVE - 1);
    localparam logic [CSW-1:0] HI_FIRST = CSW'(CSR_HI_BASE);
    localparam logic [CSW-1:0] HI_LAST  = CSW'(CSR_HI_BASE + NUM_LIVE - 1);

    logic lo_hit;
    logic hi_hit;

    assign lo_hit = (rd_csr >= LO_FIRST) && (rd_csr <= LO_LAST);
    assign hi_hit = (rd_csr >= HI_FIRST) && (rd_csr <= HI_LAST);
    assign idx_d  = rd_csr[IW-1:0];

    always_comb begin
        kind_d = RD_IDLE;
        if (rd_req) begin
            if (!lo_hit && !hi_hit) begin
                kind_d = RD_NONE;
            end else if (rd_rs1 != '0) begin
                kind_d = RD_FAULT;
            end else if (lo_hit) begin
                kind_d = rd_xlen32 ? RD_LOW : RD_FULL;
            end else begin
                kind_d = rd_xlen32 ? RD_HIGH : RD_FAULT;
            end
        end
    end

endmodule

// File: rtl/cntr_read_port.sv
module cntr_read_port
    import cntr_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int NC = NUM_CNT
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  rd_kind_e               kind_d,
    input  logic [$clog2(NC)-1:0]  idx_d,
    input  logic [NC-1:0][CW-1:0]  vis_cnt,
    output logic [CW-1:0]          rd_data,
    output logic                   rd_valid,
    output logic                   rd_fault
);

    localparam int HW = CW / 2;

    rd_kind_e      state_q;
    logic [CW-1:0] sel_q;

    // state register: read kind and sampled counter value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
            sel_q   <= '0;
        end else begin
            state_q <= kind_d;
            sel_q   <= vis_cnt[idx_d];
        end
    end

    // outputs decoded from the state
    always_comb begin
        rd_valid = 1'b1;
        rd_fault = 1'b0;
        rd_data  = '0;
        unique case (state_q)
            RD_IDLE:  rd_valid = 1'b0;
            RD_NONE:  rd_data  = '0;
            RD_FULL:  rd_data  = sel_q;
            RD_LOW:   rd_data  = {{(CW-HW){1'b0}}, sel_q[HW-1:0]};
            RD_HIGH:  rd_data  = {{(CW-HW){1'b0}}, sel_q[CW-1:HW]};
            RD_FAULT: rd_fault = 1'b1;
            default:  rd_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/hart_counter_unit.sv
module hart_counter_unit
    import cntr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [RET_W-1:0]     retire_cnt,
    input  logic                 rd_req,
    input  logic [CSR_W-1:0]     rd_csr,
    input  logic [RS_W-1:0]      rd_rs1,
    input  logic                 rd_xlen32,
    output logic [CNT_W-1:0]     rd_data,
    output logic                 rd_valid,
    output logic                 rd_fault
);

    localparam int IW = $clog2(NUM_CNT);

    logic [NUM_CNT-1:0][CNT_W-1:0]  vis_cnt;
    logic [NUM_LIVE-1:0][CNT_W-1:0] live_q;
    rd_kind_e                       kind_d;
    logic [IW-1:0]                  idx_d;
    logic [CNT_W-1:0]               cyc_cnt;
    logic [CNT_W-1:0]               tim_cnt;
    logic [CNT_W-1:0]               ins_cnt;

    assign cyc_cnt = live_q[IDX_CYCLE];
    assign tim_cnt = live_q[IDX_TIME];
    assign ins_cnt = live_q[IDX_INSTRET];

    cntr_bank #(.CW(CNT_W), .NC(NUM_CNT), .RW(RET_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .retire_cnt (retire_cnt),
        .vis_cnt    (vis_cnt),
        .live_q     (live_q)
    );

    cntr_csr_decode #(.CSW(CSR_W), .RSW(RS_W), .NC(NUM_CNT)) u_dec (
        .rd_req    (rd_req),
        .rd_csr    (rd_csr),
        .rd_rs1    (rd_rs1),
        .rd_xlen32 (rd_xlen32),
        .kind_d    (kind_d),
        .idx_d     (idx_d)
    );

    cntr_read_port #(.CW(CNT_W), .NC(NUM_CNT)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind_d   (kind_d),
        .idx_d    (idx_d),
        .vis_cnt  (vis_cnt),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .rd_fault (rd_fault)
    );

endmodule

// File: rtl/cntr_unit_checker.sv
module cntr_unit_checker
    import cntr_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [RET_W-1:0]   retire_cnt,
    input logic               rd_req,
    input logic               rd_xlen32,
    input logic [CNT_W-1:0]   rd_data,
    input logic               rd_valid,
    input logic               rd_fault,
    input logic [CNT_W-1:0]   cyc_cnt,
    input logic [CNT_W-1:0]   tim_cnt,
    input logic [CNT_W-1:0]   ins_cnt
);

    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> cyc_cnt == $past(cyc_cnt) + CNT_W'(1));                       // R2
    AST_TIME_EQ_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tim_cnt == cyc_cnt);                                                     // R2
    AST_INSTRET_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> ins_cnt == $past(ins_cnt) + CNT_W'($past(retire_cnt)));       // R3
    AST_RETIRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        retire_cnt <= RET_W'(MAX_RETIRE));                                       // R3
    AST_HIGH_WORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && rd_valid && $past(rd_xlen32)) |-> rd_data[CNT_W-1:CNT_W/2] == '0); // R6
    AST_FAULT_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fault |-> rd_data == '0);                                             // R9
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> rd_valid == $past(rd_req));                                    // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0 && !rd_fault));                             // R11

endmodule

bind hart_counter_unit cntr_unit_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .retire_cnt (retire_cnt),
    .rd_req     (rd_req),
    .rd_xlen32  (rd_xlen32),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .rd_fault   (rd_fault),
    .cyc_cnt    (cyc_cnt),
    .tim_cnt    (tim_cnt),
    .ins_cnt    (ins_cnt)
);

// File: tb/test_hart_counter_unit.sv
module test_hart_counter_unit;

    localparam int PERIOD = 10;
    localparam int WD_CYCLES = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  retire_cnt = '0;
    logic        rd_req = 1'b0;
    logic [11:0] rd_csr = '0;
    logic [4:0]  rd_rs1 = '0;
    logic        rd_xlen32 = 1'b0;
    logic [63:0] rd_data;
    logic        rd_valid;
    logic        rd_fault;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    longint unsigned m_cyc = 0;
    longint unsigned m_ins = 0;
    logic [63:0] e_data  = '0;
    logic        e_valid = 1'b0;
    logic        e_fault = 1'b0;
    string       e_tag   = "R1";

    always #(PERIOD/2) clk = ~clk;

    hart_counter_unit i_hart_counter_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .retire_cnt (retire_cnt),
        .rd_req     (rd_req),
        .rd_csr     (rd_csr),
        .rd_rs1     (rd_rs1),
        .rd_xlen32  (rd_xlen32),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .rd_fault   (rd_fault)
    );

    // reference model, evaluated from the requirements at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cyc = 0; m_ins = 0;
            e_data = '0; e_valid = 1'b0; e_fault = 1'b0; e_tag = "R1";
        end else begin
            longint unsigned vis_ins;
            longint unsigned val;
            bit lo, hi;
            vis_ins = m_ins + longint'(retire_cnt);
            lo = (rd_csr == 12'hC00) || (rd_csr == 12'hC01) || (rd_csr == 12'hC02);
            hi = (rd_csr == 12'hC80) || (rd_csr == 12'hC81) || (rd_csr == 12'hC82);
            val = (rd_csr[1:0] == 2'd2) ? vis_ins : m_cyc;
            e_valid = rd_req; e_fault = 1'b0; e_data = '0; e_tag = "R11";
            if (rd_req) begin
                if ((lo || hi) && rd_rs1 != 0) begin
                    e_fault = 1'b1; e_tag = "R9";
                end else if (hi && !rd_xlen32) begin
                    e_fault = 1'b1; e_tag = "R8";
                end else if (lo && !rd_xlen32) begin
                    e_data = val;
                    e_tag = (rd_csr[1:0] == 2'd2) ? "R3,R4,R5" : "R2,R5";
                end else if (lo) begin
                    e_data = {32'd0, val[31:0]}; e_tag = "R6";
                end else if (hi) begin
                    e_data = {32'd0, val[63:32]}; e_tag = "R7";
                end else begin
                    e_tag = "R10";
                end
            end
            m_cyc = m_cyc + 1;
            m_ins = vis_ins;
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (!done) begin
            checks += 3;
            if (rd_valid !== e_valid) begin
                fails++;
                $display("FAIL %s/R11 rd_valid actual %0b expected %0b", e_tag, rd_valid, e_valid);
            end
            if (rd_fault !== e_fault) begin
                fails++;
                $display("FAIL %s rd_fault actual %0b expected %0b", e_tag, rd_fault, e_fault);
            end
            if (rd_data !== e_data) begin
                fails++;
                $display("FAIL %s rd_data actual %h expected %h", e_tag, rd_data, e_data);
            end
        end
    end

    task automatic drive(input logic req, input logic [11:0] csr, input logic [4:0] rs1,
                         input logic x32, input logic [2:0] ret);
        @(negedge clk);
        #1;
        rd_req = req; rd_csr = csr; rd_rs1 = rs1; rd_xlen32 = x32; retire_cnt = ret;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    logic [11:0] csr_list [12] = '{12'hC00, 12'hC01, 12'hC02, 12'hC80, 12'hC81, 12'hC82,
                                   12'hC03, 12'hC1F, 12'hC83, 12'h300, 12'hC40, 12'hB02};

    initial begin
        // R1: request held during reset, outputs must stay quiet
        rd_req = 1'b1; rd_csr = 12'hC00;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        // first cycle after reset: cycle read returns 0 (R1)
        drive(1'b0, 12'h000, 5'd0, 1'b0, 3'd0);
        repeat (2) drive(1'b0, 12'h000, 5'd0, 1'b0, 3'd1);
        // every listed CSR in both modes, rs1 zero and nonzero (R5..R10)
        for (int m = 0; m < 2; m++) begin
            for (int i = 0; i < 12; i++) begin
                drive(1'b1, csr_list[i], 5'd0, m[0], 3'(i % 5));
                drive(1'b1, csr_list[i], 5'd7, m[0], 3'd2);
                drive(1'b0, csr_list[i], 5'd0, m[0], 3'd0);
            end
        end
        // R4: retire bursts of 4 with back-to-back instret reads
        for (int i = 0; i < 10; i++) drive(1'b1, 12'hC02, 5'd0, 1'b0, 3'd4);
        for (int i = 0; i < 6; i++)  drive(1'b1, 12'hC02, 5'd0, 1'b1, 3'(i % 5));
        // mixed random traffic
        for (int i = 0; i < 300; i++) begin
            drive(1'($urandom_range(0, 3) != 0), csr_list[$urandom_range(0, 11)],
                  ($urandom_range(0, 4) == 0) ? 5'($urandom_range(1, 31)) : 5'd0,
                  1'($urandom_range(0, 1)), 3'($urandom_range(0, 4)));
        end
        drive(1'b0, 12'h000, 5'd0, 1'b0, 3'd0);
        repeat (3) @(negedge clk);
        #1 finish_run();
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R11 watchdog: actual still running, expected finished");
            finish_run();
        end
    end

endmodule